// File: doc/BRIEF.md
# Dual-Mode Keyed Watchdog Timer

This block raises a system reset request when software stops servicing it. The operating mode is fixed at reset by a 16-bit selection word that the chip presents on an input while reset is held. One value gives a software mode. In that mode the watchdog sleeps until software arms it. The other values give a hardware mode that runs from reset onward and can never be stopped. The hardware mode has two variants: one pauses while the chip is in standby, and one keeps counting through standby.

Software talks to the block through one 8-bit control register. The top three bits pick which prescaler tap drives the count. The low nibble takes a 4-bit key: writing the key arms the watchdog in software mode, and writing it again later restarts the count. The count advances on single-cycle tick-enable pulses from five external prescaler taps. A request fires on the second tick after the last restart, which places the timeout between one and two tap periods. The count also restarts when the prescaler feeding the selected tap is cleared, and on entry into standby in every mode except hardware run-through-standby.

Top module: `keyed_watchdog`

## Requirements
- R1: Mode is decoded from `sel_id` while `rst_n` is low. 0xA596 gives software mode, 0xA597 gives hardware mode that pauses in standby, and any other value gives hardware mode that runs through standby. After reset `rd_data` is 0x00 in software mode and 0x30 in either hardware mode.
- R2: In software mode, before arming, tick pulses never raise `rst_req`. A write whose low nibble is not 0101 does not arm the watchdog.
- R3: The first write in software mode with low nibble 0101 arms the watchdog and captures `wr_data[7:5]` as the tap select. After that, no write changes the select bits, and the watchdog stays armed until reset.
- R4: A write with low nibble 0101 while the watchdog is armed sets the count to zero. Writes with any other low nibble leave the count unchanged.
- R5: Tap select {b7,b6,b5}: 000 selects `tick_en[0]`, 010 selects `tick_en[1]`, 100 selects `tick_en[2]`, 110 selects `tick_en[3]`, and any value with b5=1 selects `tick_en[4]`. Ticks on the other taps are ignored.
- R6: `rst_req` rises in the cycle after the second selected tick counted since the last clear. Once high, it stays high until `rst_n` is asserted.
- R7: `psc_clr[0]` clears the main timebase (taps 0 and 1), `psc_clr[1]` clears the watch prescaler (taps 2 and 3), and `psc_clr[2]` clears the sub-CR tap (tap 4). Each resets the count only when it feeds the selected tap.
- R8: A rising edge on `stby` resets the count in software mode and in hardware-pause mode, but not in hardware run-through-standby mode.
- R9: In hardware-pause mode, ticks arriving while `stby` is high are ignored.
- R10: In hardware mode the watchdog runs from reset on tap 4. The select bits read as 001, bit 4 reads 1, and writes cannot change them.
- R11: `rd_data[3:0]` always reads zero.
- R12: When a clear and a selected tick arrive in the same cycle, the clear wins and the count becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| sel_id | input | 16 | Mode selection word, sampled during reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read data |
| tick_en | input | 5 | Single-cycle tick pulses from prescaler taps |
| psc_clr | input | 3 | Prescaler clear pulses (main, watch, sub-CR) |
| stby | input | 1 | Standby level; its rising edge marks entry |
| rst_req | output | 1 | Sticky reset request |

## Verification
The embedded properties check several rules on every cycle: the request stays high once raised, the select bits and the armed state stay frozen after arming, the count never reaches the trip value, a clear forces the count to zero, a pause holds the count, the hardware select reads fixed, and an idle software watchdog never requests. Only the bench scenarios can show the rest. These are the mode decode from each selection word, which tap each select code follows, which prescaler clear affects which tap, the standby-entry exceptions per mode, and the exact tick on which the request rises.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        MODE_SW       = 2'd0,
        MODE_HW_PAUSE = 2'd1,
        MODE_HW_RUN   = 2'd2
    } wdt_mode_e;

    localparam int NUM_TAPS = 5;
    localparam int NUM_SRC  = 3;
    localparam int TAP_W    = $clog2(NUM_TAPS);
    localparam int SRC_W    = $clog2(NUM_SRC);

    // Tap index chosen by the select bits {b7,b6,b5}
    function automatic logic [TAP_W-1:0] tap_of(input logic [2:0] sel);
        if (sel[0]) return TAP_W'(4);
        return TAP_W'(sel[2:1]);
    endfunction

    // Prescaler source that feeds a given tap
    function automatic logic [SRC_W-1:0] src_of(input logic [TAP_W-1:0] tap);
        if (tap == TAP_W'(4)) return SRC_W'(2);
        if (tap >= TAP_W'(2)) return SRC_W'(1);
        return SRC_W'(0);
    endfunction

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import wdt_pkg::*;
#(
    parameter logic [15:0] ID_SW       = 16'hA596,
    parameter logic [15:0] ID_HW_PAUSE = 16'hA597,
    parameter logic [3:0]  KEY         = 4'b0101,
    parameter logic [2:0]  HW_SEL      = 3'b001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] sel_id,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output wdt_mode_e   mode_o,
    output logic        run_o,
    output logic [2:0]  sel_o,
    output logic        key_hit_o,
    output logic [7:0]  rd_data_o
);

    typedef struct packed {
        wdt_mode_e  mode;
        logic       run;
        logic [2:0] sel;
    } ctrl_t;

    ctrl_t st_q, st_d, st_rst;
    logic  key_wr;
    logic  wr_unused_b4;

    assign wr_unused_b4 = wr_data[4];
    assign key_wr       = wr_en && (wr_data[3:0] == KEY);

    always_comb begin
        st_rst = '0;
        if (sel_id == ID_SW) begin
            st_rst.mode = MODE_SW;
            st_rst.run  = 1'b0;
            st_rst.sel  = 3'b000;
        end else begin
            st_rst.mode = (sel_id == ID_HW_PAUSE) ? MODE_HW_PAUSE : MODE_HW_RUN;
            st_rst.run  = 1'b1;
            st_rst.sel  = HW_SEL;
        end
    end

    always_comb begin
        st_d = st_q;
        if (st_q.mode == MODE_SW && !st_q.run && key_wr) begin
            st_d.run = 1'b1;
            st_d.sel = wr_data[7:5];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign mode_o    = st_q.mode;
    assign run_o     = st_q.run;
    assign sel_o     = st_q.sel;
    assign key_hit_o = key_wr && st_q.run;
    assign rd_data_o = {st_q.sel, (st_q.mode != MODE_SW), 4'b0000};

    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |=> $stable(st_q.sel)); // R3
    AST_RUN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |=> st_q.run); // R3
    AST_HW_SEL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != MODE_SW) |-> (st_q.run && st_q.sel == HW_SEL)); // R10

endmodule

// File: rtl/wdt_tap_sel.sv
module wdt_tap_sel
    import wdt_pkg::*;
(
    input  logic [2:0]          sel_i,
    input  logic [NUM_TAPS-1:0] tick_en_i,
    input  logic [NUM_SRC-1:0]  psc_clr_i,
    output logic                tick_o,
    output logic                clr_o
);

    logic [TAP_W-1:0] tap;
    logic [SRC_W-1:0] src;
    logic [NUM_TAPS-1:0] tap_hit;
    logic [NUM_SRC-1:0]  src_hit;

    assign tap = tap_of(sel_i);
    assign src = src_of(tap);

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        assign tap_hit[i] = (tap == TAP_W'(i)) && tick_en_i[i];
    end

    for (genvar j = 0; j < NUM_SRC; j++) begin : g_src
        assign src_hit[j] = (src == SRC_W'(j)) && psc_clr_i[j];
    end

    assign tick_o = |tap_hit;
    assign clr_o  = |src_hit;

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int TRIP_COUNT = 2,
    localparam int CNT_W = $clog2(TRIP_COUNT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    input  logic clr_i,
    input  logic pause_i,
    output logic req_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } cnt_t;

    cnt_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (run_i && !st_q.req) begin
            if (clr_i) begin
                st_d.cnt = '0;
            end else if (tick_i && !pause_i) begin
                if (st_q.cnt == CNT_W'(TRIP_COUNT - 1)) st_d.req = 1'b1;
                else                                    st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;

    AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |=> st_q.req); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !st_q.req) |=> !st_q.req); // R2
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !st_q.req) |=> (st_q.cnt == '0)); // R12
    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_i && !clr_i) |=> $stable(st_q.cnt)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(TRIP_COUNT)); // R6

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdt_pkg::*;
#(
    parameter logic [15:0] ID_SW       = 16'hA596,
    parameter logic [15:0] ID_HW_PAUSE = 16'hA597,
    parameter logic [3:0]  KEY         = 4'b0101,
    parameter int          TRIP_COUNT  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] sel_id,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    input  logic [4:0]  tick_en,
    input  logic [2:0]  psc_clr,
    input  logic        stby,
    output logic        rst_req
);

    typedef struct packed {
        logic stby;
    } top_t;

    top_t      st_q, st_d;
    wdt_mode_e mode;
    logic      run, key_hit, tap_tick, tap_clr;
    logic      stby_rise, stby_clr, pause, any_clr;
    logic [2:0] sel;

    wdt_ctrl_reg #(
        .ID_SW(ID_SW), .ID_HW_PAUSE(ID_HW_PAUSE), .KEY(KEY), .HW_SEL(3'b001)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_id(sel_id),
        .wr_en(wr_en), .wr_data(wr_data),
        .mode_o(mode), .run_o(run), .sel_o(sel),
        .key_hit_o(key_hit), .rd_data_o(rd_data)
    );

    wdt_tap_sel u_tap (
        .sel_i(sel), .tick_en_i(tick_en), .psc_clr_i(psc_clr),
        .tick_o(tap_tick), .clr_o(tap_clr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.stby = stby;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stby_rise = stby && !st_q.stby;
    assign stby_clr  = stby_rise && (mode != MODE_HW_RUN);
    assign pause     = (mode == MODE_HW_PAUSE) && stby;
    assign any_clr   = key_hit || tap_clr || stby_clr;

    wdt_count #(.TRIP_COUNT(TRIP_COUNT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(run),
        .tick_i(tap_tick), .clr_i(any_clr), .pause_i(pause),
        .req_o(rst_req)
    );

    AST_KEY_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (rd_data[3:0] == 4'b0000)); // R11

endmodule

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sel_id = 16'hA596;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic [4:0]  tick_en = '0;
    logic [2:0]  psc_clr = '0;
    logic        stby = 1'b0;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    keyed_watchdog dut (
        .clk(clk), .rst_n(rst_n), .sel_id(sel_id),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .tick_en(tick_en), .psc_clr(psc_clr), .stby(stby), .rst_req(rst_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [15:0] id);
        @(negedge clk);
        rst_n = 1'b0; sel_id = id; wr_en = 0; tick_en = '0; psc_clr = '0; stby = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick(input int idx);
        tick_en = 5'(1 << idx);
        @(negedge clk);
        tick_en = '0;
        @(negedge clk);
    endtask

    task automatic pclr(input int idx);
        psc_clr = 3'(1 << idx);
        @(negedge clk);
        psc_clr = '0;
        @(negedge clk);
    endtask

    // {select bits, a tap that must be ignored, the tap that must count}
    localparam logic [8:0] VEC [6] = '{
        {3'b000, 3'd1, 3'd0},
        {3'b010, 3'd0, 3'd1},
        {3'b100, 3'd3, 3'd2},
        {3'b110, 3'd2, 3'd3},
        {3'b001, 3'd0, 3'd4},
        {3'b111, 3'd3, 3'd4}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Table walk: software mode with each select code (R3, R5, R6)
        for (int v = 0; v < 6; v++) begin
            do_reset(16'hA596);
            wr({VEC[v][8:6], 5'b00101});
            chk("R3 select captured", rd_data, {VEC[v][8:6], 5'b0});
            for (int k = 0; k < 3; k++) tick(int'(VEC[v][5:3]));
            tick(int'(VEC[v][2:0]));
            chk("R5 wrong tap ignored, one tick", {7'b0, rst_req}, 8'h00);
            tick(int'(VEC[v][2:0]));
            chk("R6 second tick trips", {7'b0, rst_req}, 8'h01);
        end

        // R1 R10 R11: hardware run-through mode
        do_reset(16'h1234);
        chk("R1 hw reset value", rd_data, 8'h30);
        wr(8'hC5);
        chk("R10 hw select not writable", rd_data, 8'h30);
        chk("R11 key nibble zero", {4'b0, rd_data[3:0]}, 8'h00);
        tick(0); tick(0);
        chk("R10 hw ignores tap0", {7'b0, rst_req}, 8'h00);
        tick(4); tick(4);
        chk("R10 hw runs on tap4", {7'b0, rst_req}, 8'h01);
        wr(8'h05);
        chk("R6 request sticky", {7'b0, rst_req}, 8'h01);
        do_reset(16'hA596);
        chk("R6 cleared by reset / R1 sw value", {7'b0, rst_req} | rd_data, 8'h00);

        // R2 idle software mode
        for (int k = 0; k < 3; k++) begin tick(0); tick(4); end
        chk("R2 idle no request", {7'b0, rst_req}, 8'h00);
        wr(8'hE3);
        chk("R2 non-key write no arm", rd_data, 8'h00);
        tick(0); tick(0);
        chk("R2 still idle", {7'b0, rst_req}, 8'h00);
        wr(8'h05);
        wr(8'h45);
        chk("R3 select locked after arming", rd_data, 8'h00);
        tick(0); wr(8'h05); tick(0);
        chk("R4 key write clears", {7'b0, rst_req}, 8'h00);
        wr(8'h0A); tick(0);
        chk("R4 non-key write keeps count", {7'b0, rst_req}, 8'h01);

        // R7 prescaler clears
        do_reset(16'hA596);
        wr(8'h85);
        tick(2); pclr(0); tick(2);
        chk("R7 unrelated prescaler clear ignored", {7'b0, rst_req}, 8'h01);
        do_reset(16'hA596);
        wr(8'h85);
        tick(2); pclr(1); tick(2);
        chk("R7 feeding prescaler clears", {7'b0, rst_req}, 8'h00);
        tick_en = 5'b00100; psc_clr = 3'b010;
        @(negedge clk);
        tick_en = '0; psc_clr = '0;
        @(negedge clk);
        tick(2);
        chk("R12 clear beats tick", {7'b0, rst_req}, 8'h00);
        tick(2);
        chk("R12 counts after clear", {7'b0, rst_req}, 8'h01);

        // R8 standby entry
        do_reset(16'hA596);
        wr(8'h25);
        tick(4);
        stby = 1; @(negedge clk); stby = 0; @(negedge clk);
        tick(4);
        chk("R8 sw standby entry clears", {7'b0, rst_req}, 8'h00);
        do_reset(16'hFFFF);
        tick(4);
        stby = 1; @(negedge clk); stby = 0; @(negedge clk);
        tick(4);
        chk("R8 hw-run standby does not clear", {7'b0, rst_req}, 8'h01);

        // R9 hardware pause mode
        do_reset(16'hA597);
        chk("R1 hw-pause reset value", rd_data, 8'h30);
        tick(4);
        stby = 1; @(negedge clk);
        for (int k = 0; k < 3; k++) tick(4);
        chk("R9 ticks ignored in standby", {7'b0, rst_req}, 8'h00);
        stby = 0; @(negedge clk);
        tick(4);
        chk("R8 hw-pause entry cleared count", {7'b0, rst_req}, 8'h00);
        tick(4);
        chk("R9 counts after standby", {7'b0, rst_req}, 8'h01);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule